// File: doc/BRIEF.md
# Dual-Channel Serial ADC Reader

This block runs the host side of a three-wire link to a converter that holds two differential channels at the same instant and then returns both codes in one serial frame. It raises a convert strobe and toggles a serial clock made from the system clock. On every rising serial clock edge it takes one bit from the serial data line. When the frame is complete it shows two signed 14-bit results, together with a one-cycle valid pulse.

A frame can be requested with a single-cycle start pulse. A request that comes in while a frame is running or while pacing forbids a launch is held until a launch is allowed. A free-run level makes the block start frames back to back, each one as soon as the pacing rules permit. Two rules govern pacing. The first is a fixed minimum spacing between convert strobes. The second is a programmable acquisition gap, measured from the last rising serial clock edge of one frame to the strobe of the next.

Top module: `dual_adc_reader`

## Requirements
- R1: The convert strobe rises only while the serial clock is low. It stays high for exactly H system clocks. Its fall coincides with the first rising serial clock edge, and it is never high while the serial clock is high.
- R2: Each serial clock half period lasts H system clocks. H is the value of sck_half at launch, and a value of 0 counts as 1. Changing sck_half during a frame has no effect on that frame.
- R3: A frame has exactly 32 rising serial clock edges, and sdata is sampled at each of them. The serial clock returns low H cycles after the 32nd rising edge and stays low until the next launch.
- R4: Number the bits 1 to 32 in order of arrival. Bits 3..16 form channel 0 and bits 19..32 form channel 1, MSB first in both cases. Bits 1, 2, 17 and 18 are discarded. ch0 and ch1 are 14-bit two's-complement values, so a raw code of 8192 or more reads as code minus 16384.
- R5: frame_valid is a single-cycle pulse. It is high in the cycle after the edge of the 32nd rising serial clock edge, which is 63*H cycles after the strobe is first seen high. ch0 and ch1 change only in the cycles where frame_valid is high.
- R6: Two rising edges of the strobe are at least MIN_FRAME_CYC system clocks apart.
- R7: The strobe rises no sooner than acq_gap system clocks after the 32nd rising serial clock edge of the previous frame.
- R8: While free_run is high, frames repeat with a strobe period of max(64*H+1, MIN_FRAME_CYC, 63*H+acq_gap).
- R9: A start pulse received during a busy frame is remembered and served as soon as the pacing rules allow. No frame starts without start or free_run.
- R10: A synchronous reset drives the strobe, the serial clock, frame_valid and both results to 0 and abandons any frame in progress. It also clears the pacing history, so the first request after reset launches in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle frame request |
| free_run | input | 1 | Level: run frames back to back |
| sck_half | input | DIV_W | Serial clock half period in system clocks (0 counts as 1) |
| acq_gap | input | GAP_W | Minimum cycles from the 32nd rising serial clock edge to the next strobe |
| sdata | input | 1 | Serial data from the converter |
| conv | output | 1 | Convert strobe |
| sclk | output | 1 | Serial clock |
| ch0 | output | DATA_W | Channel 0 result, signed |
| ch1 | output | DATA_W | Channel 1 result, signed |
| frame_valid | output | 1 | One-cycle pulse when new results are present |

## Verification
The hardest conditions to reach from the ports are the launch points where each of the three pacing limits is the binding one: the frame length itself, the fixed minimum spacing, and the acquisition gap. The bench reaches each of them in free-run with chosen pairs of half period and gap, and compares the measured strobe period with the closed-form maximum. A start pulse issued while a frame is running, a divider change made inside a frame, and a reset that cuts a frame short are each driven on purpose. A sweep over every small half period and several edge-value code patterns, with varying filler bits, checks decoding and timing together.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } rd_state_t;

  // Effective serial half period: zero is promoted to one system clock.
  function automatic int unsigned eff_half(input int unsigned h);
    return (h == 0) ? 1 : h;
  endfunction

  // True when bit index idx (0-based, arrival order) carries payload,
  // given a frame of two halves, each pad bits followed by dat bits.
  function automatic logic is_payload(input int unsigned idx,
                                      input int unsigned pad,
                                      input int unsigned dat);
    return (idx % (pad + dat)) >= pad;
  endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             half_tick
);

  logic [DIV_W-1:0] hcnt;

  assign half_tick = run && (hcnt == half - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || half_tick) hcnt <= '0;
    else                          hcnt <= hcnt + DIV_W'(1);
  end

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int PAD_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     take,
  input  logic                     sdata,
  output logic                     last_take,
  output logic signed [DATA_W-1:0] res0,
  output logic signed [DATA_W-1:0] res1,
  output logic                     res_valid
);

  localparam int FRAME_BITS = 2 * (PAD_W + DATA_W);
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int SH_W       = 2 * DATA_W - 1;

  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic             keep;

  assign keep      = is_payload(int'(cnt), PAD_W, DATA_W);
  assign last_take = take && (cnt == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sh        <= '0;
      res0      <= '0;
      res1      <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (take) begin
        cnt <= cnt + CNT_W'(1);
        if (keep) sh <= {sh[SH_W-2:0], sdata};
        if (last_take) begin
          res0      <= $signed(sh[SH_W-1:DATA_W-1]);
          res1      <= $signed({sh[DATA_W-2:0], sdata});
          res_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_rd_pacer.sv
module adc_rd_pacer #(
  parameter int GAP_W         = 8,
  parameter int MIN_FRAME_CYC = 67
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             rise_last,
  input  logic [GAP_W-1:0] acq_gap,
  output logic             ready
);

  localparam int               PER_W   = $clog2(MIN_FRAME_CYC + 1);
  localparam logic [PER_W-1:0] PER_TOP = PER_W'(MIN_FRAME_CYC);
  localparam logic [GAP_W-1:0] GAP_TOP = '1;

  logic [PER_W-1:0] per_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic             per_ok;
  logic             gap_ok;

  assign per_ok = per_cnt >= PER_TOP;
  assign gap_ok = gap_cnt >= acq_gap;
  assign ready  = per_ok && gap_ok;

  always_ff @(posedge clk) begin
    if (rst)                  per_cnt <= PER_TOP;
    else if (launch)          per_cnt <= PER_W'(1);
    else if (per_cnt < PER_TOP) per_cnt <= per_cnt + PER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                    gap_cnt <= GAP_TOP;
    else if (rise_last)         gap_cnt <= GAP_W'(1);
    else if (gap_cnt != GAP_TOP) gap_cnt <= gap_cnt + GAP_W'(1);
  end

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W        = 14,
  parameter int PAD_W         = 2,
  parameter int DIV_W         = 8,
  parameter int GAP_W         = 8,
  parameter int MIN_FRAME_CYC = 67
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     free_run,
  input  logic [DIV_W-1:0]         sck_half,
  input  logic [GAP_W-1:0]         acq_gap,
  input  logic                     sdata,
  output logic                     conv,
  output logic                     sclk,
  output logic signed [DATA_W-1:0] ch0,
  output logic signed [DATA_W-1:0] ch1,
  output logic                     frame_valid
);

  localparam int FRAME_BITS = 2 * (PAD_W + DATA_W);

  rd_state_t        state;
  logic [DIV_W-1:0] half_q;
  logic             req_pend;
  logic             busy;
  logic             half_tick;
  logic             rise_evt;
  logic             last_take;
  logic             ready;
  logic             launch;

  // Named internal events, also observed by the bound checker.
  assign busy     = (state != ST_IDLE);
  assign launch   = !busy && ready && (req_pend || start || free_run);
  assign rise_evt = half_tick && !sclk && (state == ST_LEAD || state == ST_SHIFT);

  adc_rd_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .half      (half_q),
    .half_tick (half_tick)
  );

  adc_rd_shifter #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .clear     (launch),
    .take      (rise_evt),
    .sdata     (sdata),
    .last_take (last_take),
    .res0      (ch0),
    .res1      (ch1),
    .res_valid (frame_valid)
  );

  adc_rd_pacer #(.GAP_W(GAP_W), .MIN_FRAME_CYC(MIN_FRAME_CYC)) u_pace (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .rise_last (last_take),
    .acq_gap   (acq_gap),
    .ready     (ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      conv     <= 1'b0;
      sclk     <= 1'b0;
      half_q   <= DIV_W'(1);
      req_pend <= 1'b0;
    end else begin
      if (launch)     req_pend <= 1'b0;
      else if (start) req_pend <= 1'b1;

      case (state)
        ST_IDLE: if (launch) begin
          state  <= ST_LEAD;
          conv   <= 1'b1;
          half_q <= DIV_W'(eff_half(32'(sck_half)));
        end
        ST_LEAD: if (half_tick) begin
          sclk  <= 1'b1;
          conv  <= 1'b0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (half_tick) begin
          sclk <= ~sclk;
          if (last_take) state <= ST_TAIL;
        end
        ST_TAIL: if (half_tick) begin
          sclk  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
  parameter int FRAME_BITS    = 32,
  parameter int GAP_W         = 8,
  parameter int MIN_FRAME_CYC = 67
) (
  input logic             clk,
  input logic             rst,
  input logic             conv,
  input logic             sclk,
  input logic             frame_valid,
  input logic             launch,
  input logic             rise_evt,
  input logic [GAP_W-1:0] acq_gap
);

  localparam int SAT = 1 << 20;

  logic armed;
  logic p_conv;
  int   rises;
  int   since_conv;
  int   since_fv;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      p_conv     <= 1'b0;
      rises      <= 0;
      since_conv <= MIN_FRAME_CYC;
      since_fv   <= SAT;
    end else begin
      armed  <= 1'b1;
      p_conv <= conv;
      if (launch)        rises <= 0;
      else if (rise_evt) rises <= rises + 1;
      if (conv && !p_conv)   since_conv <= 1;
      else if (since_conv < SAT) since_conv <= since_conv + 1;
      if (frame_valid)       since_fv <= 1;
      else if (since_fv < SAT) since_fv <= since_fv + 1;
    end
  end

  // R1
  conv_sclk_excl_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !(conv && sclk));

  // R1
  conv_drop_edge_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(conv) |-> $rose(sclk));

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    frame_valid |=> !frame_valid);

  // R3
  rise_total_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    frame_valid |-> (rises == FRAME_BITS));

  // R6
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(conv) |-> (since_conv >= MIN_FRAME_CYC));

  // R7
  acq_window_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(conv) |-> (since_fv >= int'(acq_gap)));

endmodule

bind dual_adc_reader adc_rd_checker #(
  .FRAME_BITS    (FRAME_BITS),
  .GAP_W         (GAP_W),
  .MIN_FRAME_CYC (MIN_FRAME_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .conv        (conv),
  .sclk        (sclk),
  .frame_valid (frame_valid),
  .launch      (launch),
  .rise_evt    (rise_evt),
  .acq_gap     (acq_gap)
);

// File: tb/sim_dual_adc_reader.sv
module sim_dual_adc_reader;

  localparam int CLK_PERIOD = 10;
  localparam int MINF       = 67;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        free_run = 1'b0;
  logic        sdata = 1'b0;
  logic [7:0]  sck_half = 8'd1;
  logic [7:0]  acq_gap = 8'd0;
  logic        conv;
  logic        sclk;
  logic        frame_valid;
  logic signed [13:0] ch0;
  logic signed [13:0] ch1;

  dual_adc_reader #(
    .DATA_W(14), .PAD_W(2), .DIV_W(8), .GAP_W(8), .MIN_FRAME_CYC(MINF)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .free_run(free_run),
    .sck_half(sck_half), .acq_gap(acq_gap), .sdata(sdata),
    .conv(conv), .sclk(sclk), .ch0(ch0), .ch1(ch1), .frame_valid(frame_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Monitor and converter model, all at the falling edge.
  int cyc = 0, t_launch = 0, per_meas = 0, launches = 0, rises = 0, lead = 0;
  int idx = 32, fvs = 0, fv_lat = 0, fv_rises = 0, got0 = 0, got1 = 0;
  int fv_double = 0, ch_glitch = 0;
  bit fall_ok = 1'b0, p_conv = 1'b0, p_sclk = 1'b0, p_fv = 1'b0;
  logic [31:0] word = '0, next_word = '0;
  logic [13:0] p0 = '0, p1 = '0;

  always @(negedge clk) begin
    cyc++;
    if (conv && !p_conv) begin
      launches++;
      per_meas = cyc - t_launch;
      t_launch = cyc;
      rises = 0; lead = 0; fall_ok = 1'b0;
      word = next_word; idx = 0;
    end
    if (conv) lead++;
    if (!conv && p_conv) fall_ok = sclk && !p_sclk;
    if (sclk && !p_sclk) begin
      rises++;
      if (idx < 32) idx++;
    end
    if (frame_valid) begin
      fvs++;
      fv_lat = cyc - t_launch;
      fv_rises = rises;
      got0 = int'(ch0);
      got1 = int'(ch1);
      if (p_fv) fv_double++;
    end
    if (!frame_valid && !rst && (ch0 !== p0 || ch1 !== p1)) ch_glitch++;
    p0 = ch0; p1 = ch1;
    p_conv = conv; p_sclk = sclk; p_fv = frame_valid;
    sdata = (idx < 32) ? word[31-idx] : 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= 8192) ? v - 16384 : v;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_fv(input int n0);
    while (fvs == n0) @(posedge clk);
  endtask

  // One requested frame; the divider is changed to h2 once the frame is running.
  task automatic run_one(input int h, input int a, input int b, input int h2, input int p);
    int he = (h == 0) ? 1 : h;
    int n0 = fvs;
    next_word = {2'(p), 14'(a), 2'(~p), 14'(b)};
    sck_half = 8'(h);
    pulse_start();
    sck_half = 8'(h2);
    wait_fv(n0);
    check(got0 == sx(a), "R4 ch0", got0, sx(a));
    check(got1 == sx(b), "R4 ch1", got1, sx(b));
    check(fv_lat == 63*he, "R5/R2 valid latency", fv_lat, 63*he);
    check(fv_rises == 32, "R3 rising edges", fv_rises, 32);
    check(lead == he && fall_ok, "R1 strobe lead", lead, he);
    repeat (he + 2) @(negedge clk);
    check(sclk == 1'b0, "R3 clock parked low", int'(sclk), 0);
  endtask

  task automatic run_free(input int h, input int g, input string tag);
    int n0 = launches;
    int exp = max3(64*h + 1, MINF, 63*h + g);
    int f0;
    acq_gap = 8'(g);
    sck_half = 8'(h);
    next_word = {2'b11, 14'h2abc, 2'b00, 14'h0155};
    @(negedge clk) free_run = 1'b1;
    while (launches < n0 + 3) @(posedge clk);
    @(negedge clk) free_run = 1'b0;
    check(per_meas == exp, tag, per_meas, exp);
    f0 = fvs;
    wait_fv(f0);
    check(got0 == sx(14'h2abc) && got1 == 14'h0155, "R8 free-run data", got0, sx(14'h2abc));
    repeat (h + 3) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(conv == 0 && sclk == 0 && frame_valid == 0, "R10 reset outputs",
          int'({conv, sclk, frame_valid}), 0);
    rst = 1'b0;

    // Sweep of half periods and code patterns (R1..R5, R2 mid-frame change)
    for (int h = 0; h < 4; h++) begin
      for (int p = 0; p < 6; p++) begin
        int a, b;
        case (p)
          0: begin a = 0;      b = 16383; end
          1: begin a = 16383;  b = 0;     end
          2: begin a = 8192;   b = 8191;  end
          3: begin a = 8191;   b = 8192;  end
          4: begin a = 5461;   b = 10922; end
          default: begin a = (h*5843 + 911) % 16384; b = (h*2719 + 4001) % 16384; end
        endcase
        run_one(h, a, b, h ^ 3, p);
      end
    end

    // Free-run pacing: each limit binds in turn
    run_free(1, 0,   "R6 min spacing binds");
    run_free(1, 40,  "R7 acquisition gap binds");
    run_free(2, 0,   "R8 frame length binds");
    run_free(2, 100, "R7 long gap binds");
    run_free(3, 0,   "R8 frame length h3");

    // No frame without a request
    acq_gap = 8'd0;
    n = launches;
    repeat (300) @(posedge clk);
    check(launches == n, "R9 idle without request", launches, n);

    // Request during a busy frame is held
    sck_half = 8'd1;
    n = launches;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    while (launches < n + 2) @(posedge clk);
    check(per_meas == MINF, "R9 held request period", per_meas, MINF);
    repeat (80) @(negedge clk);

    // Reset in the middle of a frame
    next_word = {2'b01, 14'h1234, 2'b10, 14'h3ff0};
    pulse_start();
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(conv == 0 && sclk == 0 && frame_valid == 0 && ch0 == 0 && ch1 == 0,
          "R10 reset mid-frame", int'({conv, sclk, frame_valid}), 0);
    @(negedge clk) rst = 1'b0;
    n = launches;
    pulse_start();
    @(posedge clk);
    check(launches == n + 1, "R10 immediate launch after reset", launches, n + 1);
    wait_fv(fvs);
    check(got0 == 14'h1234 && got1 == sx(14'h3ff0), "R10 R4 data after reset", got1, sx(14'h3ff0));
    repeat (5) @(negedge clk);

    check(fv_double == 0, "R5 valid width", fv_double, 0);
    check(ch_glitch == 0, "R5 results stable between pulses", ch_glitch, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule